// File: doc/BRIEF.md
# Chainable Serial DAC Front End

This block is the digital side of a serially programmed digital-to-analog converter. A host drives three wires: a serial clock, a data line and an active-low chip select. While the select is low, each rising serial clock edge pushes one data bit into a 16-bit shift register. When the select returns high, the low 12 bits of that register are copied into the converter code latch. The latch drives a parallel code output, which stands in for the resistor string and output amplifier.

The oldest bit of the shift register leaves on a serial output, and it changes on falling serial clock edges. Connecting that output to the data input of a second copy builds a chain, so one select and one clock can program several converters with one long stream. A resolution parameter of 8, 10 or 12 sets how many upper latch bits carry meaning. The remaining low bits are forced to zero.

All three pins are asynchronous to the system clock. Each pin passes through a synchroniser, and edges are found by comparing the synchronised level with its previous sample. The system clock must run at least four times faster than the serial clock.

Top module: `chain_dac_front`

## Requirements
- R1: Data bits enter the shift register on rising serial clock edges while the select is low, first bit sent is the most significant.
- R2: While the select is high, the shift register does not change, whatever the serial clock and data lines do.
- R3: In a 16-bit frame, the first four bits sent never reach the code latch.
- R4: On a rising edge of the select, the code latch takes the low 12 bits of the shift register. code_o[11] is the fifth bit of a 16-bit frame, and code_o[0] is the last bit.
- R5: The serial output changes only after a falling serial clock edge seen while the select is low. It then takes the oldest register bit, so a bit appears there on the sixteenth falling edge after it entered.
- R6: While the select is high, the serial output keeps its last value.
- R7: After reset, code_o, dout_o and update_o are all zero.
- R8: A frame of only 12 bits programs the latch fully, because the last 12 bits sent form the code.
- R9: If the serial clock is already high when the select falls, no shift results. Only later rising edges count.
- R10: When RESOLUTION is below 12, the low 12-RESOLUTION bits of code_o are always zero.
- R11: update_o pulses high for exactly one system clock per rising edge of the select. It rises in the same cycle that code_o takes its new value, and code_o changes in no other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_n_i | input | 1 | Select, active low, asynchronous |
| sdin_i | input | 1 | Serial data in, asynchronous |
| dout_o | output | 1 | Serial data out, feeds the next device in a chain |
| code_o | output | DATA_BITS (12) | Latched converter code, left-justified |
| update_o | output | 1 | One-cycle strobe when code_o loads |

## Verification
The hardest situation to reach is a select falling while the serial clock is already high. A stray rising edge in that state would move one bit and shift the whole serial output stream by one place. The stimulus holds the clock high, drops the select, and lowers the clock before sending a short frame. It checks the serial output after every falling edge against a bench shift model, so any stray shift shows up as a mismatch. A second instance built at 8-bit resolution receives the same random frames with nonzero trailing bits, which exercises the masking path.

// File: rtl/cdac_pkg.sv
package cdac_pkg;

  // Index of each asynchronous pin inside the synchroniser vector.
  typedef enum int unsigned {
    PIN_SCLK = 0,
    PIN_CS   = 1,
    PIN_SDIN = 2
  } pin_idx_e;

  localparam int unsigned PIN_COUNT = 3;

  // Ones on the upper `res` bits of a `data_bits` wide field, zeros below.
  function automatic logic [31:0] keep_mask(int data_bits, int res);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < data_bits && i >= data_bits - res) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned OUT_BITS   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk_lvl,
  input  logic                cs_lvl,
  input  logic                sdin_lvl,
  output logic                dout_o,
  output logic [OUT_BITS-1:0] low_o
);

  localparam int unsigned TOP = FRAME_BITS - 1;

  logic [FRAME_BITS-1:0] shreg;
  logic                  sclk_prev;
  logic                  sclk_rise;
  logic                  sclk_fall;
  logic                  active;

  assign sclk_rise = sclk_lvl & ~sclk_prev;
  assign sclk_fall = ~sclk_lvl & sclk_prev;
  assign active    = ~cs_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      shreg     <= '0;
      dout_o    <= 1'b0;
    end else begin
      sclk_prev <= sclk_lvl;
      if (sclk_rise && active) shreg <= {shreg[TOP-1:0], sdin_lvl};
      if (sclk_fall && active) dout_o <= shreg[TOP];
    end
  end

  assign low_o = shreg[OUT_BITS-1:0];

endmodule

// File: rtl/code_latch.sv
module code_latch
  import cdac_pkg::*;
#(
  parameter int unsigned DATA_BITS  = 12,
  parameter int unsigned RESOLUTION = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_lvl,
  input  logic [DATA_BITS-1:0] data_i,
  output logic [DATA_BITS-1:0] code_o,
  output logic                 upd_o
);

  localparam logic [DATA_BITS-1:0] KEEP =
    DATA_BITS'(keep_mask(int'(DATA_BITS), int'(RESOLUTION)));

  logic cs_prev;
  logic load;

  assign load = cs_lvl & ~cs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev <= 1'b1;
      code_o  <= '0;
      upd_o   <= 1'b0;
    end else begin
      cs_prev <= cs_lvl;
      upd_o   <= load;
      if (load) code_o <= data_i & KEEP;
    end
  end

endmodule

// File: rtl/chain_dac_front.sv
module chain_dac_front
  import cdac_pkg::*;
#(
  parameter int unsigned FRAME_BITS  = 16,
  parameter int unsigned DATA_BITS   = 12,
  parameter int unsigned RESOLUTION  = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk_i,
  input  logic                 cs_n_i,
  input  logic                 sdin_i,
  output logic                 dout_o,
  output logic [DATA_BITS-1:0] code_o,
  output logic                 update_o
);

  // Select idles high so reset never fakes an edge on it.
  localparam logic [PIN_COUNT-1:0] PIN_RST = PIN_COUNT'(1) << PIN_CS;

  logic [PIN_COUNT-1:0] pin_raw;
  logic [PIN_COUNT-1:0] pin_lvl;
  logic                 sclk_lvl;
  logic                 cs_lvl;
  logic                 sdin_lvl;
  logic [DATA_BITS-1:0] data_low;

  always_comb begin
    pin_raw           = '0;
    pin_raw[PIN_SCLK] = sclk_i;
    pin_raw[PIN_CS]   = cs_n_i;
    pin_raw[PIN_SDIN] = sdin_i;
  end

  sync_chain #(
    .WIDTH  (PIN_COUNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(pin_raw),
    .q_o(pin_lvl)
  );

  assign sclk_lvl = pin_lvl[PIN_SCLK];
  assign cs_lvl   = pin_lvl[PIN_CS];
  assign sdin_lvl = pin_lvl[PIN_SDIN];

  frame_shifter #(
    .FRAME_BITS(FRAME_BITS),
    .OUT_BITS  (DATA_BITS)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sclk_lvl(sclk_lvl),
    .cs_lvl  (cs_lvl),
    .sdin_lvl(sdin_lvl),
    .dout_o  (dout_o),
    .low_o   (data_low)
  );

  code_latch #(
    .DATA_BITS (DATA_BITS),
    .RESOLUTION(RESOLUTION)
  ) u_latch (
    .clk   (clk),
    .rst   (rst),
    .cs_lvl(cs_lvl),
    .data_i(data_low),
    .code_o(code_o),
    .upd_o (update_o)
  );

endmodule

// File: rtl/chain_dac_front_chk.sv
module chain_dac_front_chk #(
  parameter int unsigned DATA_BITS  = 12,
  parameter int unsigned RESOLUTION = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs_lvl,
  input logic                 sclk_lvl,
  input logic                 dout,
  input logic                 upd,
  input logic [DATA_BITS-1:0] code,
  input logic [DATA_BITS-1:0] data_low
);

  localparam int unsigned PAD = DATA_BITS - RESOLUTION;

  AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    upd |=> !upd); // R11

  AST_UPD_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    upd |-> ($past(cs_lvl) && !$past(cs_lvl, 2))); // R11

  AST_CODE_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (rst)
    !upd |-> $stable(code)); // R4

  AST_NO_SHIFT_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> $stable(data_low)); // R2

  AST_DOUT_HOLD_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> $stable(dout)); // R6

  AST_DOUT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !($past(sclk_lvl) && !sclk_lvl) |=> $stable(dout)); // R5

  if (PAD > 0) begin : g_pad
    AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
      code[PAD-1:0] == '0); // R10
  end

endmodule

bind chain_dac_front chain_dac_front_chk #(
  .DATA_BITS (DATA_BITS),
  .RESOLUTION(RESOLUTION)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_lvl  (cs_lvl),
  .sclk_lvl(sclk_lvl),
  .dout    (dout_o),
  .upd     (update_o),
  .code    (code_o),
  .data_low(data_low)
);

// File: tb/sim_chain_dac_front.sv
`timescale 1ns/1ps
module sim_chain_dac_front;

  localparam int HALF = 8;   // system clocks per serial clock phase

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdin = 1'b0;

  logic        dout0, dout1, upd0, upd1;
  logic [11:0] code0, code1;

  int checks = 0;
  int errors = 0;
  int upd_cnt0 = 0;
  int upd_cnt1 = 0;

  // Bench model of the serial path
  logic [15:0] m_sh = '0;
  logic        m_dout = 1'b0;

  always #10 clk = ~clk;

  chain_dac_front u0 (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .sdin_i(sdin),
    .dout_o(dout0), .code_o(code0), .update_o(upd0)
  );

  chain_dac_front #(.RESOLUTION(8)) u1 (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .sdin_i(sdin),
    .dout_o(dout1), .code_o(code1), .update_o(upd1)
  );

  always @(posedge clk) begin
    if (upd0) upd_cnt0 <= upd_cnt0 + 1;
    if (upd1) upd_cnt1 <= upd_cnt1 + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] exp_code(input logic [15:0] sh, input int res);
    logic [11:0] m;
    m = '1;
    for (int i = 0; i < 12 - res; i++) m[i] = 1'b0;
    return sh[11:0] & m;
  endfunction

  // One serial bit: data set, rising edge, falling edge, output checked.
  task automatic send_bit(input logic b, input string req);
    sdin = b;
    tick(HALF);
    sclk = 1'b1;
    if (!cs_n) m_sh = {m_sh[14:0], b};
    tick(HALF);
    sclk = 1'b0;
    if (!cs_n) m_dout = m_sh[15];
    tick(4);
    chk(req, {31'd0, dout0}, {31'd0, m_dout});
  endtask

  task automatic close_frame(input string req);
    int c0, c1;
    c0 = upd_cnt0;
    c1 = upd_cnt1;
    cs_n = 1'b1;
    tick(HALF);
    chk(req, {20'd0, code0}, {20'd0, exp_code(m_sh, 12)});
    chk("R10", {20'd0, code1}, {20'd0, exp_code(m_sh, 8)});
    chk("R11", upd_cnt0 - c0, 1);
    chk("R11", upd_cnt1 - c1, 1);
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input string req);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = nbits - 1; i >= 0; i--) send_bit(w[i], "R5");
    close_frame(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(5);
    rst = 1'b0;
    tick(3);
    chk("R7", {20'd0, code0}, 32'd0);
    chk("R7", {31'd0, dout0}, 32'd0);
    chk("R7", {31'd0, upd0}, 32'd0);

    // Directed frames
    frame(16'h0A5C, 16, "R1");
    frame(16'hF000, 16, "R3");
    frame(16'hFFFF, 16, "R4");
    frame(16'h0000, 16, "R4");
    frame(16'h5ACF, 16, "R3");

    // R6 / R2: serial clock toggles while the select is high
    begin
      logic keep_dout;
      logic [11:0] keep_code;
      keep_dout = dout0;
      keep_code = code0;
      for (int k = 0; k < 6; k++) send_bit(1'b1, "R6");
      chk("R6", {31'd0, dout0}, {31'd0, keep_dout});
      chk("R2", {20'd0, code0}, {20'd0, keep_code});
      // Empty select pulse reloads the unchanged register
      cs_n = 1'b0;
      tick(HALF);
      close_frame("R2");
    end

    // R8: short 12-bit frames
    frame(16'h0C3A, 12, "R8");
    frame(16'h0777, 12, "R8");

    // R9: serial clock high when the select falls
    frame(16'h9E21, 16, "R9");
    sclk = 1'b1;
    tick(HALF);
    cs_n = 1'b0;
    tick(HALF);
    sclk = 1'b0;
    m_dout = m_sh[15];
    tick(4);
    chk("R9", {31'd0, dout0}, {31'd0, m_dout});
    tick(HALF);
    for (int i = 11; i >= 0; i--) send_bit(i[0] ^ i[2], "R9");
    close_frame("R9");

    // Random frames, full and short
    for (int n = 0; n < 40; n++) begin
      logic [15:0] w;
      w = 16'($urandom);
      frame(w, ($urandom % 4 == 0) ? 12 : 16, "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule